// File: doc/BRIEF.md
# Multi-Port Stream Switch with Held Arbitration

This block steers beats from several ready/valid stream inputs onto several stream outputs. Every beat carries data, an end-of-packet flag and a destination field. The target output comes from one of two places, chosen at build time. In the first, the destination field is compared against an inclusive address window that belongs to each output. In the second, the destination field is ignored and a small routing table, written through a one-entry write port, names the output for each input. A beat whose destination reaches no output is accepted and thrown away, so its input never stalls.

Each output has its own arbiter. It grants one requesting input, using either fixed priority or rotating priority. The grant then stays with that input until a release condition ends it. A release can come from a count of completed beats, from a run of cycles in which the owner offers nothing to that output, or from an end-of-packet beat. A value of zero turns each of these conditions off. Beats move straight from the granted input to the output without storage. A new grant takes one arbitration cycle. A shared clock-enable freezes every handshake and all arbiter state.

Top module: `stream_switch`

## Requirements
- R1: In the first cycle after reset, no output presents a valid beat, because no grant exists yet.
- R2: In address-window mode, a beat goes to the lowest-numbered output whose window [base, high] contains its destination, with data, end flag and destination unchanged. It appears on that output one cycle after it first requests a free output. The default windows are 0..3 for output 0 and 4..7 for output 1.
- R3: In address-window mode, a valid beat whose destination lies in no window is accepted, with input ready high in the same cycle, and no output shows it.
- R4: In table mode, the destination field has no effect. Entry i of the table selects the output for input i. After reset, entry i holds i mod the number of outputs. A write of cfg_out to entry cfg_in with cfg_we high changes routing from the next cycle.
- R5: With rotating priority, a free output grants the first requesting input found by searching upward from just after the input it granted most recently, wrapping at the top.
- R6: With fixed priority, a free output grants the lowest-numbered requesting input.
- R7: With MAX_XFERS > 0, the grant ends after MAX_XFERS completed beats. The output then shows one empty arbitration cycle before it serves its next owner.
- R8: With IDLE_LIMIT > 0, the grant ends after IDLE_LIMIT consecutive cycles in which the owner offers no beat to that output, and no beat is transferred in that time.
- R9: With RELEASE_ON_LAST = 1, the grant ends with the beat whose end flag is set. With RELEASE_ON_LAST = 0, that beat does not end the grant.
- R10: While clk_en is low, every output valid and every input ready is low, and no arbiter state changes.
- R11: While an output is valid and its ready is low, the output stays valid with stable data, and the source input's ready stays low.
- R12: Every completed beat at an output coincides with a completed handshake at an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock enable for handshakes and state |
| s_valid | input | NUM_IN | Input beat valid, one bit per input |
| s_ready | output | NUM_IN | Input beat accepted |
| s_data | input | NUM_IN*DATA_W | Input data, input i at bits i*DATA_W |
| s_last | input | NUM_IN | Input end-of-packet flag |
| s_dest | input | NUM_IN*DEST_W | Input destination field |
| m_valid | output | NUM_OUT | Output beat valid |
| m_ready | input | NUM_OUT | Output sink ready |
| m_data | output | NUM_OUT*DATA_W | Output data |
| m_last | output | NUM_OUT | Output end-of-packet flag |
| m_dest | output | NUM_OUT*DEST_W | Output destination field |
| cfg_we | input | 1 | Routing table write strobe |
| cfg_in | input | idx_w(NUM_IN) | Table entry (input index) to write |
| cfg_out | input | idx_w(NUM_OUT) | Output index to store |

## Verification
A wrong owner, or a grant that is never dropped, shows on the ports as data from the wrong input, or as a missing empty cycle, within one or two cycles of the point where a release or grant should happen. The bench therefore counts cycles exactly around every release edge: the count limit, the idle run and the end-of-packet beat. It then checks which input's data appears right after the empty arbitration cycle, which also shows whether the rotating-priority pointer is correct. Routing faults show at once as a beat on the wrong output or as a beat that is neither accepted nor shown.

// File: rtl/sw_pkg.sv
package sw_pkg;

    localparam int MAX_PORTS  = 16;
    localparam int PORT_IDX_W = 4;

    typedef struct packed {
        logic                  hit;
        logic [PORT_IDX_W-1:0] idx;
    } pick_t;

    function automatic int idx_w(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int cnt_w(int n);
        return (n > 0) ? $clog2(n + 1) : 1;
    endfunction

    // Search n request bits; with rotate set, begin just above 'recent'.
    function automatic pick_t pick_port(logic [MAX_PORTS-1:0] req,
                                        logic [PORT_IDX_W-1:0] recent,
                                        logic rotate, int n);
        pick_t r;
        int    c;
        r = '0;
        for (int k = 0; k < MAX_PORTS; k++) begin
            c = rotate ? (int'(recent) + 1 + k) % n : k;
            if (k < n && !r.hit && req[c]) begin
                r.hit = 1'b1;
                r.idx = PORT_IDX_W'(c);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/sw_dest_decode.sv
module sw_dest_decode import sw_pkg::*; #(
    parameter int NUM_OUT = 2,
    parameter int DEST_W  = 4,
    parameter bit USE_REG = 1'b0,
    parameter logic [NUM_OUT*DEST_W-1:0] BASE = '0,
    parameter logic [NUM_OUT*DEST_W-1:0] HIGH = '0,
    parameter int OUT_W = idx_w(NUM_OUT)
) (
    input  logic [DEST_W-1:0]  dest,
    input  logic [OUT_W-1:0]   sel,
    output logic [NUM_OUT-1:0] hit
);

    logic found;

    always_comb begin
        hit   = '0;
        found = 1'b0;
        for (int o = 0; o < NUM_OUT; o++) begin
            if (USE_REG) begin
                hit[o] = (sel == OUT_W'(o));
            end else if (!found &&
                         dest >= BASE[o*DEST_W +: DEST_W] &&
                         dest <= HIGH[o*DEST_W +: DEST_W]) begin
                hit[o] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    logic unused_mode;
    assign unused_mode = USE_REG ? ^dest : ^sel;

endmodule

// File: rtl/sw_out_arbiter.sv
module sw_out_arbiter import sw_pkg::*; #(
    parameter int NUM_IN          = 3,
    parameter int MAX_XFERS       = 4,
    parameter int IDLE_LIMIT      = 3,
    parameter bit RELEASE_ON_LAST = 1'b1,
    parameter bit ROUND_ROBIN     = 1'b1,
    parameter int IN_W            = idx_w(NUM_IN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic [NUM_IN-1:0] req,
    input  logic              xfer,
    input  logic              beat_last,
    output logic              busy,
    output logic [IN_W-1:0]   owner
);

    localparam int XW = cnt_w(MAX_XFERS);
    localparam int IW = cnt_w(IDLE_LIMIT);

    logic [IN_W-1:0] recent;
    logic [XW-1:0]   xcnt;
    logic [IW-1:0]   icnt;
    pick_t           pk;
    logic            rel_cnt, rel_last, rel_idle;

    always_comb begin
        pk       = pick_port(MAX_PORTS'(req), PORT_IDX_W'(recent), ROUND_ROBIN, NUM_IN);
        rel_cnt  = (MAX_XFERS > 0) && (int'(xcnt) + 1 >= MAX_XFERS);
        rel_last = RELEASE_ON_LAST && beat_last;
        rel_idle = (IDLE_LIMIT > 0) && (int'(icnt) + 1 >= IDLE_LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            owner  <= '0;
            recent <= '0;
            xcnt   <= '0;
            icnt   <= '0;
        end else if (clk_en) begin
            if (!busy) begin
                if (pk.hit) begin
                    busy   <= 1'b1;
                    owner  <= pk.idx[IN_W-1:0];
                    recent <= pk.idx[IN_W-1:0];
                    xcnt   <= '0;
                    icnt   <= '0;
                end
            end else if (xfer) begin
                if (rel_cnt || rel_last) busy <= 1'b0;
                xcnt <= xcnt + 1'b1;
                icnt <= '0;
            end else if (!req[owner]) begin
                if (rel_idle) busy <= 1'b0;
                icnt <= icnt + 1'b1;
            end else begin
                icnt <= '0;
            end
        end
    end

    logic unused_pick;
    assign unused_pick = ^pk;

endmodule

// File: rtl/stream_switch.sv
module stream_switch import sw_pkg::*; #(
    parameter int NUM_IN          = 3,
    parameter int NUM_OUT         = 2,
    parameter int DATA_W          = 8,
    parameter int DEST_W          = 4,
    parameter bit USE_REG_ROUTE   = 1'b0,
    parameter bit ROUND_ROBIN     = 1'b1,
    parameter int MAX_XFERS       = 4,
    parameter int IDLE_LIMIT      = 3,
    parameter bit RELEASE_ON_LAST = 1'b1,
    parameter logic [NUM_OUT*DEST_W-1:0] DEST_BASE = {4'd4, 4'd0},
    parameter logic [NUM_OUT*DEST_W-1:0] DEST_HIGH = {4'd7, 4'd3}
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clk_en,
    input  logic [NUM_IN-1:0]           s_valid,
    output logic [NUM_IN-1:0]           s_ready,
    input  logic [NUM_IN*DATA_W-1:0]    s_data,
    input  logic [NUM_IN-1:0]           s_last,
    input  logic [NUM_IN*DEST_W-1:0]    s_dest,
    output logic [NUM_OUT-1:0]          m_valid,
    input  logic [NUM_OUT-1:0]          m_ready,
    output logic [NUM_OUT*DATA_W-1:0]   m_data,
    output logic [NUM_OUT-1:0]          m_last,
    output logic [NUM_OUT*DEST_W-1:0]   m_dest,
    input  logic                        cfg_we,
    input  logic [idx_w(NUM_IN)-1:0]    cfg_in,
    input  logic [idx_w(NUM_OUT)-1:0]   cfg_out
);

    localparam int IN_W  = idx_w(NUM_IN);
    localparam int OUT_W = idx_w(NUM_OUT);

    logic [OUT_W-1:0]   route_tbl [NUM_IN];
    logic [NUM_OUT-1:0] hit       [NUM_IN];
    logic [IN_W-1:0]    owner     [NUM_OUT];
    logic [NUM_OUT-1:0] busy;
    logic [NUM_OUT-1:0] xfer;
    logic [NUM_IN-1:0]  ready_raw;

    // Routing table: written through the simple config port.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_IN; i++) route_tbl[i] <= OUT_W'(i % NUM_OUT);
        end else if (cfg_we && int'(cfg_in) < NUM_IN) begin
            route_tbl[cfg_in] <= cfg_out;
        end
    end

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
        sw_dest_decode #(
            .NUM_OUT (NUM_OUT),
            .DEST_W  (DEST_W),
            .USE_REG (USE_REG_ROUTE),
            .BASE    (DEST_BASE),
            .HIGH    (DEST_HIGH),
            .OUT_W   (OUT_W)
        ) u_dec (
            .dest (s_dest[gi*DEST_W +: DEST_W]),
            .sel  (route_tbl[gi]),
            .hit  (hit[gi])
        );
    end

    for (genvar go = 0; go < NUM_OUT; go++) begin : g_out
        logic [NUM_IN-1:0] req;

        always_comb begin
            for (int i = 0; i < NUM_IN; i++) req[i] = s_valid[i] & hit[i][go];
        end

        sw_out_arbiter #(
            .NUM_IN          (NUM_IN),
            .MAX_XFERS       (MAX_XFERS),
            .IDLE_LIMIT      (IDLE_LIMIT),
            .RELEASE_ON_LAST (RELEASE_ON_LAST),
            .ROUND_ROBIN     (ROUND_ROBIN),
            .IN_W            (IN_W)
        ) u_arb (
            .clk       (clk),
            .rst       (rst),
            .clk_en    (clk_en),
            .req       (req),
            .xfer      (xfer[go]),
            .beat_last (s_last[owner[go]]),
            .busy      (busy[go]),
            .owner     (owner[go])
        );

        assign m_valid[go] = clk_en & busy[go] & req[owner[go]];
        assign xfer[go]    = m_valid[go] & m_ready[go];
        assign m_data[go*DATA_W +: DATA_W] = s_data[owner[go]*DATA_W +: DATA_W];
        assign m_dest[go*DEST_W +: DEST_W] = s_dest[owner[go]*DEST_W +: DEST_W];
        assign m_last[go]  = s_last[owner[go]];
    end

    // Ready: unroutable beats are swallowed; routed beats follow the sink.
    always_comb begin
        for (int i = 0; i < NUM_IN; i++) begin
            ready_raw[i] = ~|hit[i];
            for (int o = 0; o < NUM_OUT; o++) begin
                if (busy[o] && owner[o] == IN_W'(i) && hit[i][o] && m_ready[o])
                    ready_raw[i] = 1'b1;
            end
        end
    end

    assign s_ready = {NUM_IN{clk_en}} & ready_raw;

endmodule

// File: rtl/sw_switch_chk.sv
module sw_switch_chk #(
    parameter int NUM_IN  = 3,
    parameter int NUM_OUT = 2,
    parameter int DATA_W  = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      clk_en,
    input logic [NUM_IN-1:0]         s_valid,
    input logic [NUM_IN-1:0]         s_ready,
    input logic [NUM_OUT-1:0]        m_valid,
    input logic [NUM_OUT-1:0]        m_ready,
    input logic [NUM_OUT*DATA_W-1:0] m_data
);

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (m_valid == '0));

    a_r10_enable_stall: assert property (@(posedge clk) disable iff (rst)
        !clk_en |-> (m_valid == '0 && s_ready == '0));

    a_r12_xfer_source: assert property (@(posedge clk) disable iff (rst)
        |(m_valid & m_ready) |-> |(s_valid & s_ready));

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_hold
        a_r11_hold: assert property (@(posedge clk) disable iff (rst)
            (clk_en && m_valid[o] && !m_ready[o]) |=>
            (!clk_en || (m_valid[o] && $stable(m_data[o*DATA_W +: DATA_W]))));
    end

endmodule

bind stream_switch sw_switch_chk #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT),
    .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/tb_stream_switch.sv
module tb_stream_switch;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clk_en = 1'b1;
    always #5 clk = ~clk;

    // Instance A: address windows, rotating priority, count 4 / idle 3 / end flag.
    logic [2:0]  s_valid = '0, s_ready, s_last = '0;
    logic [23:0] s_data = '0;
    logic [11:0] s_dest = '0;
    logic [1:0]  m_valid, m_last, m_ready = 2'b11;
    logic [15:0] m_data;
    logic [7:0]  m_dest;

    // Instance B: routing table, fixed priority, count 2 / idle 1 / end flag off.
    logic [2:0]  b_valid = '0, b_ready, b_last = '0;
    logic [23:0] b_data = '0;
    logic [11:0] b_dest = '0;
    logic [1:0]  bm_valid, bm_last;
    logic [15:0] bm_data;
    logic [7:0]  bm_dest;
    logic        b_we = 1'b0;
    logic [1:0]  b_cin = '0;
    logic        b_cout = 1'b0;

    stream_switch dut (
        .clk(clk), .rst(rst), .clk_en(clk_en),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_last(s_last), .s_dest(s_dest),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .m_last(m_last), .m_dest(m_dest),
        .cfg_we(1'b0), .cfg_in(2'b00), .cfg_out(1'b0)
    );

    stream_switch #(
        .USE_REG_ROUTE(1'b1), .ROUND_ROBIN(1'b0),
        .MAX_XFERS(2), .IDLE_LIMIT(1), .RELEASE_ON_LAST(1'b0)
    ) dut_fp (
        .clk(clk), .rst(rst), .clk_en(clk_en),
        .s_valid(b_valid), .s_ready(b_ready), .s_data(b_data),
        .s_last(b_last), .s_dest(b_dest),
        .m_valid(bm_valid), .m_ready(2'b11), .m_data(bm_data),
        .m_last(bm_last), .m_dest(bm_dest),
        .cfg_we(b_we), .cfg_in(b_cin), .cfg_out(b_cout)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic put(input int p, input bit v, input int d, input int dat, input bit l);
        s_valid[p] = v;
        s_dest[p*4 +: 4] = 4'(d);
        s_data[p*8 +: 8] = 8'(dat);
        s_last[p] = l;
    endtask

    task automatic putb(input int p, input bit v, input int d, input int dat, input bit l);
        b_valid[p] = v;
        b_dest[p*4 +: 4] = 4'(d);
        b_data[p*8 +: 8] = 8'(dat);
        b_last[p] = l;
    endtask

    task automatic idle(input int n);
        s_valid = '0; s_last = '0;
        b_valid = '0; b_last = '0;
        repeat (n) tick();
    endtask

    task automatic t_reset();
        repeat (3) tick();
        rst = 1'b0;
        #2;
        chk("R1 m_valid after reset", m_valid, 0);
        chk("R1 table-mode m_valid after reset", bm_valid, 0);
        tick();
    endtask

    task automatic t_window_route();
        put(0, 1, 2, 8'hA5, 1);
        #2; chk("R2 grant cycle empty", m_valid, 0);
        tick();
        #2;
        chk("R2 routed to output 0", m_valid, 2'b01);
        chk("R2 data", m_data[7:0], 8'hA5);
        chk("R2 dest", m_dest[3:0], 2);
        chk("R2 last", m_last[0], 1);
        chk("R12 source handshake", s_ready[0], 1);
        tick();
        put(0, 0, 0, 0, 0);
        put(1, 1, 5, 8'h3C, 1);
        #2; chk("R2 second grant cycle", m_valid, 0);
        tick();
        #2;
        chk("R2 routed to output 1", m_valid, 2'b10);
        chk("R2 data output 1", m_data[15:8], 8'h3C);
        tick();
        idle(4);
    endtask

    task automatic t_drop();
        put(1, 1, 12, 8'hEE, 0);
        #2;
        chk("R3 unmatched accepted", s_ready[1], 1);
        chk("R3 no output", m_valid, 0);
        tick();
        #2; chk("R3 still no output", m_valid, 0);
        idle(2);
    endtask

    task automatic t_rotate_last();
        put(0, 1, 1, 8'h10, 1);
        put(2, 1, 1, 8'h20, 1);
        #2; tick();
        #2;
        chk("R5 rotation picks input 2", m_data[7:0], 8'h20);
        chk("R5 output valid", m_valid[0], 1);
        chk("R5 input 0 waits", s_ready[0], 0);
        chk("R5 input 2 ready", s_ready[2], 1);
        tick();
        put(2, 0, 0, 0, 0);
        #2; chk("R9 end flag released grant", m_valid[0], 0);
        tick();
        #2;
        chk("R5 wrap to input 0", m_data[7:0], 8'h10);
        chk("R5 input 0 valid", m_valid[0], 1);
        tick();
        idle(4);
    endtask

    task automatic t_count_release();
        put(0, 1, 3, 8'h40, 0);
        put(1, 1, 3, 8'h50, 0);
        #2; tick();
        for (int k = 0; k < 4; k++) begin
            #2;
            chk("R7 owner input 1 beat", m_data[7:0], 8'h50);
            chk("R7 owner valid", m_valid[0], 1);
            tick();
        end
        #2; chk("R7 released after count", m_valid[0], 0);
        tick();
        #2; chk("R5 next owner input 0", m_data[7:0], 8'h40);
        tick();
        idle(4);
    endtask

    task automatic t_idle_release();
        put(0, 1, 6, 8'h61, 0);
        put(1, 1, 6, 8'h71, 0);
        #2; tick();
        #2; chk("R8 first owner input 0", m_data[15:8], 8'h61);
        tick();
        put(0, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) begin
            #2;
            chk("R8 no beat while idle", m_valid[1], 0);
            chk("R8 waiting input blocked", s_ready[1], 0);
            tick();
        end
        #2; chk("R8 arbitration cycle", m_valid[1], 0);
        tick();
        #2;
        chk("R8 input 1 served after idle run", m_data[15:8], 8'h71);
        chk("R8 valid", m_valid[1], 1);
        tick();
        idle(4);
    endtask

    task automatic t_backpressure();
        m_ready[0] = 1'b0;
        put(2, 1, 0, 8'h99, 0);
        #2; tick();
        for (int k = 0; k < 3; k++) begin
            #2;
            chk("R11 valid held", m_valid[0], 1);
            chk("R11 data held", m_data[7:0], 8'h99);
            chk("R11 source not ready", s_ready[2], 0);
            tick();
        end
        m_ready[0] = 1'b1;
        #2; chk("R11 source ready with sink", s_ready[2], 1);
        tick();
        idle(4);
    endtask

    task automatic t_clock_enable();
        clk_en = 1'b0;
        put(2, 1, 0, 8'h77, 0);
        put(1, 1, 12, 8'h00, 0);
        for (int k = 0; k < 2; k++) begin
            #2;
            chk("R10 outputs stalled", m_valid, 0);
            chk("R10 inputs stalled", s_ready, 0);
            tick();
        end
        clk_en = 1'b1;
        put(1, 0, 0, 0, 0);
        #2; chk("R10 no grant taken while stalled", m_valid, 0);
        tick();
        #2; chk("R10 resumes", m_data[7:0], 8'h77);
        tick();
        idle(4);
    endtask

    task automatic t_table_route();
        putb(1, 1, 0, 8'h11, 0);
        #2; chk("R4 grant cycle", bm_valid, 0);
        tick();
        #2;
        chk("R4 reset table sends input 1 to output 1", bm_valid, 2'b10);
        chk("R4 data", bm_data[15:8], 8'h11);
        tick();
        idle(3);
        b_we = 1'b1; b_cin = 2'd1; b_cout = 1'b0;
        tick();
        b_we = 1'b0;
        putb(1, 1, 7, 8'h12, 0);
        #2; tick();
        #2;
        chk("R4 rewritten entry sends to output 0", bm_valid, 2'b01);
        chk("R4 data after write", bm_data[7:0], 8'h12);
        tick();
        idle(3);
    endtask

    task automatic t_fixed();
        putb(0, 1, 5, 8'hA0, 1);
        putb(1, 1, 5, 8'hA1, 1);
        putb(2, 1, 5, 8'hA2, 1);
        #2; tick();
        #2; chk("R6 lowest input wins", bm_data[7:0], 8'hA0);
        tick();
        #2;
        chk("R9 end flag ignored when disabled", bm_valid[0], 1);
        chk("R9 same owner", bm_data[7:0], 8'hA0);
        tick();
        #2; chk("R7 count release", bm_valid[0], 0);
        tick();
        #2; chk("R6 lowest wins again", bm_data[7:0], 8'hA0);
        tick();
        idle(3);
    endtask

    initial begin
        t_reset();
        t_window_route();
        t_drop();
        t_rotate_last();
        t_count_release();
        t_idle_release();
        t_backpressure();
        t_clock_enable();
        t_table_route();
        t_fixed();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule